// File: doc/BRIEF.md
# Late-Arrival Detecting Pipeline Register with One-Cycle Recovery

This block is a pipeline register for paths run close to their timing limit. Each lane holds a main register loaded on the rising edge of the system clock `clk`. It also holds a shadow register loaded from the same input on the rising edge of `clk_late`, a delayed copy of that clock. The delay is less than the high phase of `clk`, so both captures fall in the same cycle. Data that arrives after the `clk` edge but before the `clk_late` edge reaches the shadow but misses the main register. A comparator per lane sees the difference, and a correction mux then forwards the shadow value, which is taken as correct, to the output. Transient upsets of the main flop are caught the same way.

Any lane mismatch drives a small recovery controller. It has two states. In RUN, the normal state, the controller moves RUN→RECOVER when any lane mismatches and stays RUN→RUN otherwise. At the edge where it enters RECOVER, every main register reloads from its shadow and ignores its input. While the controller is in RECOVER, the shadows hold their contents. RECOVER→RUN happens unconditionally at the next edge. The `stall` output is high exactly while the controller is in RECOVER. Upstream logic uses it to gate its clock for that one cycle, so each error costs exactly one cycle. Generating the clock delay, controlling the supply and replaying instructions all belong to the surrounding system.

Top module: `tedr_pipe_reg`

## Requirements
- R1: While `rst_n` is low, `q_out`, `stage_err` and `stall` are all zero, and the main and shadow registers of every lane are cleared. This holds even if reset arrives during a recovery cycle.
- R2: With data stable across both clock edges, `q_out` shows the value captured at the last rising `clk` edge. `stage_err` and `stall` stay zero.
- R3: If a lane's input changes after the rising `clk` edge but before the rising `clk_late` edge, then after the `clk_late` edge of that same cycle the lane's slice of `q_out` shows the late value. `stall` is still low in that cycle.
- R4: At the next rising `clk` edge after a mismatch, bit i of `stage_err` goes high for each mismatching lane i (lane i occupies `q_out`/`d_in` bits [i*WIDTH +: WIDTH]). `stall` goes high at the same edge.
- R5: `stall` is high for exactly one clock cycle per error event. The controller follows RUN→RECOVER→RUN.
- R6: At the edge that enters RECOVER, each main register reloads its shadow value and `d_in` is discarded. `q_out` keeps the late value through the stalled cycle. The input present at the edge that ends RECOVER is captured normally.
- R7: At the edge that ends RECOVER, `stage_err` returns to zero when no new mismatch has occurred.
- R8: The stall is global. A mismatch in any one lane stalls all lanes, so lanes with no error also discard their input at the recovery edge and keep their `stage_err` bit low. Several lanes failing in the same cycle give a single one-cycle stall.
- R9: A late arrival in the cycle just after recovery (launched at the edge that ends RECOVER) is a new event. `stall` is low for that cycle and high again for one cycle after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; main registers and recovery controller |
| clk_late | input | 1 | Delayed copy of `clk`; shadow registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | LANES*WIDTH | Lane data, lane i at bits [i*WIDTH +: WIDTH] |
| q_out | output | LANES*WIDTH | Corrected lane data |
| stage_err | output | LANES | Per-lane timing error flag |
| stall | output | 1 | Global one-cycle stall request |

## Verification
The bench sweeps every pair of early and late values on one lane. The pair with equal values must raise no error. A design whose comparator or mux is wrong would either stall on equal data or forward the stale main value. Another test changes the inputs during the recovery edge. A design that kept clocking its main registers in that cycle would show the new data one cycle early. Further tests cover a late arrival in a lane with no errors elsewhere, simultaneous failures in two lanes, an event launched at the very edge that ends recovery, and reset in the middle of a stall. These catch a stall that lasts two cycles, merges two events, only partly resets, or leaves the error flag set.

// File: rtl/tedr_pkg.sv
package tedr_pkg;

    // Recovery controller states
    typedef enum logic {
        REC_RUN   = 1'b0,
        REC_STALL = 1'b1
    } rec_state_e;

endpackage

// File: rtl/tedr_lane.sv
module tedr_lane #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             clk_late,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    input  logic             reload_i,
    input  logic             hold_i,
    output logic [WIDTH-1:0] q_o,
    output logic             mism_o,
    output logic             err_o
);

    logic [WIDTH-1:0] main_q;
    logic [WIDTH-1:0] shadow_q;
    logic             err_q;

    // Main capture on the system clock; reload from shadow on recovery edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
        end else if (reload_i) begin
            main_q <= shadow_q;
        end else begin
            main_q <= d_i;
        end
    end

    // Shadow capture on the delayed clock; frozen while the pipeline is stalled
    always_ff @(posedge clk_late or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (!hold_i) begin
            shadow_q <= d_i;
        end
    end

    // Comparison settles after the delayed edge; it is sampled at the next clk edge
    always_comb begin
        mism_o = (main_q != shadow_q);
    end

    // Correction mux: the shadow value wins whenever the two disagree
    always_comb begin
        q_o = mism_o ? shadow_q : main_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= mism_o;
        end
    end

    assign err_o = err_q;

endmodule

// File: rtl/tedr_recovery_fsm.sv
module tedr_recovery_fsm
    import tedr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_mism_i,
    output logic reload_o,
    output logic stall_o
);

    rec_state_e state_q;
    rec_state_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REC_RUN:   state_d = any_mism_i ? REC_STALL : REC_RUN;
            REC_STALL: state_d = REC_RUN;
            default:   state_d = REC_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REC_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        reload_o = 1'b0;
        stall_o  = 1'b0;
        unique case (state_q)
            REC_RUN: begin
                reload_o = any_mism_i;
                stall_o  = 1'b0;
            end
            REC_STALL: begin
                reload_o = 1'b0;
                stall_o  = 1'b1;
            end
            default: begin
                reload_o = 1'b0;
                stall_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tedr_pipe_reg.sv
module tedr_pipe_reg #(
    parameter int LANES = 4,
    parameter int WIDTH = 16
) (
    input  logic                   clk,
    input  logic                   clk_late,
    input  logic                   rst_n,
    input  logic [LANES*WIDTH-1:0] d_in,
    output logic [LANES*WIDTH-1:0] q_out,
    output logic [LANES-1:0]       stage_err,
    output logic                   stall
);

    logic [LANES-1:0] lane_mism;
    logic             any_mism;
    logic             reload;
    logic             stall_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tedr_lane #(
            .WIDTH(WIDTH)
        ) u_lane (
            .clk      (clk),
            .clk_late (clk_late),
            .rst_n    (rst_n),
            .d_i      (d_in[g*WIDTH +: WIDTH]),
            .reload_i (reload),
            .hold_i   (stall_w),
            .q_o      (q_out[g*WIDTH +: WIDTH]),
            .mism_o   (lane_mism[g]),
            .err_o    (stage_err[g])
        );
    end

    assign any_mism = |lane_mism;

    tedr_recovery_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_mism_i (any_mism),
        .reload_o   (reload),
        .stall_o    (stall_w)
    );

    assign stall = stall_w;

endmodule

// File: rtl/tedr_checker.sv
module tedr_checker #(
    parameter int LANES = 4,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES*WIDTH-1:0] q_out,
    input logic [LANES-1:0]       stage_err,
    input logic                   stall
);

    assert_stall_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    assert_stall_has_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (stage_err != '0));

    assert_err_raises_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage_err != '0) |-> stall);

    assert_err_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (stage_err == '0));

    assert_output_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> $stable(q_out));

endmodule

bind tedr_pipe_reg tedr_checker #(
    .LANES(LANES),
    .WIDTH(WIDTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_out     (q_out),
    .stage_err (stage_err),
    .stall     (stall)
);

// File: tb/sim_tedr_pipe_reg.sv
`timescale 1ns/100ps
module sim_tedr_pipe_reg;

    localparam int LANES = 2;
    localparam int WIDTH = 4;

    logic             clk = 1'b0;
    logic             clk_late = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       d_in = '0;
    logic [7:0]       q_out;
    logic [1:0]       stage_err;
    logic             stall;

    int n_cmp = 0;
    int n_bad = 0;

    tedr_pipe_reg #(.LANES(LANES), .WIDTH(WIDTH)) u0 (
        .clk(clk), .clk_late(clk_late), .rst_n(rst_n),
        .d_in(d_in), .q_out(q_out), .stage_err(stage_err), .stall(stall)
    );

    // 200 MHz clock; delayed copy trails by 1 ns (inside the 2.5 ns high phase)
    initial begin
        #5;
        forever begin
            clk = 1'b1;
            #1   clk_late = 1'b1;
            #1.5 clk = 1'b0;
            #1   clk_late = 1'b0;
            #1.5;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // state after a rising clk edge, sampled at the following falling edge
    task automatic chk_all(input string req, input logic [7:0] q, input logic [1:0] e, input logic s);
        chk({req, " q_out"}, 32'(q_out), 32'(q));
        chk({req, " stage_err"}, 32'(stage_err), 32'(e));
        chk({req, " stall"}, 32'(stall), 32'(s));
    endtask

    task automatic late_change(input logic [7:0] v);
        @(posedge clk);
        #0.5 d_in = v;
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 8'h00, 2'b00, 1'b0);
        d_in = 8'h5A;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R2 first capture", 8'h5A, 2'b00, 1'b0);

        // Sweep all early/late pairs on lane 0, lane 1 held at 9
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [7:0] va;
                logic [7:0] vb;
                va = {4'h9, 4'(a)};
                vb = {4'h9, 4'(b)};
                @(negedge clk);
                d_in = va;
                @(posedge clk);
                late_change(vb);
                @(negedge clk);
                chk("R3 mux forwards late value", 32'(q_out), 32'(vb));
                chk("R3 no stall yet", 32'(stall), 32'h0);
                @(negedge clk);
                if (a != b) begin
                    chk_all("R4 R5 R6 recovery cycle", vb, 2'b01, 1'b1);
                end else begin
                    chk_all("R2 equal data no error", vb, 2'b00, 1'b0);
                end
                @(negedge clk);
                chk_all("R5 R7 after recovery", vb, 2'b00, 1'b0);
            end
        end

        // R6 R8: late on lane 1 only; inputs changed at the recovery edge are dropped
        @(negedge clk);
        d_in = 8'h53;
        @(posedge clk);
        late_change(8'h63);
        @(negedge clk);
        chk("R3 lane1 late", 32'(q_out), 32'h63);
        d_in = 8'hAC;
        @(negedge clk);
        chk_all("R6 R8 discard at recovery edge", 8'h63, 2'b10, 1'b1);
        @(negedge clk);
        chk_all("R6 capture after recovery", 8'hAC, 2'b00, 1'b0);

        // R8: both lanes late together -> one stall
        @(negedge clk);
        d_in = 8'h11;
        @(posedge clk);
        late_change(8'hEE);
        @(negedge clk);
        chk("R3 both lanes late", 32'(q_out), 32'hEE);
        @(negedge clk);
        chk_all("R8 both lanes flagged", 8'hEE, 2'b11, 1'b1);
        @(negedge clk);
        chk_all("R8 single stall cycle", 8'hEE, 2'b00, 1'b0);

        // R9: new event launched at the edge ending recovery
        @(negedge clk);
        d_in = 8'h20;
        @(posedge clk);
        late_change(8'h24);
        @(negedge clk);
        d_in = 8'h30;
        @(negedge clk);
        chk_all("R9 first event stall", 8'h24, 2'b01, 1'b1);
        late_change(8'h3F);
        @(negedge clk);
        chk_all("R9 run cycle between events", 8'h3F, 2'b00, 1'b0);
        @(negedge clk);
        chk_all("R9 second event stall", 8'h3F, 2'b01, 1'b1);
        @(negedge clk);
        chk_all("R9 second event done", 8'h3F, 2'b00, 1'b0);

        // R1: reset in the middle of a stall
        @(negedge clk);
        d_in = 8'h77;
        @(posedge clk);
        late_change(8'h7B);
        @(negedge clk);
        @(negedge clk);
        chk("R1 stall before reset", 32'(stall), 32'h1);
        rst_n = 1'b0;
        #0.5;
        chk_all("R1 reset during stall", 8'h00, 2'b00, 1'b0);
        @(negedge clk);
        chk_all("R1 reset held", 8'h00, 2'b00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R2 capture after reset", 8'h7B, 2'b00, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule